// File: doc/BRIEF.md
# Inverse Clarke Transform Unit

This unit turns a pair of stationary-frame components, alpha and beta, back into phase quantities of a balanced three-phase system. In a balanced system the three phases sum to zero, so only phase A and phase B are produced. A downstream stage that needs the third phase derives it as the negated sum of the other two. Phase A equals alpha. Phase B equals (sqrt(3)·beta − alpha)/2, computed in fixed point.

All data are signed two's complement and `DW` bits wide. The factor sqrt(3)/2 is held as the unsigned 16-fraction-bit constant 56756. Alpha is weighted by 32768, which is one half in the same scale. The difference of the two products is formed at full precision and then rounded once: 32768 is added and the sum is shifted arithmetically right by 16. The rounded result is clamped to the `DW`-bit signed range.

Both outputs come two clock cycles after their inputs are sampled. An input strobe travels with the data and marks which output cycles carry results. Every register updates on the rising clock edge. A synchronous active-high reset clears the pipeline.

Top module: `ab_to_phase`

## Requirements
- R1: `ph_a` equals the `alpha` value sampled two rising edges earlier, when neither of those edges saw `rst` high.
- R2: Before clamping, `ph_b` equals floor((56756·beta − 32768·alpha + 32768) / 65536), using the `alpha` and `beta` values sampled two edges earlier. This is round-to-nearest with halves rounded upward. For example, beta = 0 and alpha = 1 gives 0, and alpha = −1 gives 1.
- R3: When the rounded phase B value exceeds 2^(DW−1)−1, `ph_b` is that maximum. When it is below −2^(DW−1), `ph_b` is that minimum. For example, with DW = 6, alpha = 31 and beta = −32 give −32.
- R4: `out_vld` equals the `in_vld` value sampled two edges earlier.
- R5: A rising edge with `rst` high clears `ph_a`, `ph_b` and `out_vld` to 0. It also discards the sample already in the first stage, so the edge that follows the reset edge presents zeros as well.
- R6: `ph_a`, `ph_b` and `out_vld` always belong to the same input sample. Both data paths have the same two-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks alpha/beta as a valid sample |
| alpha | input | DW | Alpha component, signed |
| beta | input | DW | Beta component, signed |
| out_vld | output | 1 | Marks ph_a/ph_b as a valid result |
| ph_a | output | DW | Phase A, signed |
| ph_b | output | DW | Phase B, signed, rounded and clamped |

## Verification
A reset can land in the same cycle that a valid sample occupies the first pipeline stage. In that case the clearing of the pipeline and the normal forward flow of the sample collide. The bench provokes this by raising `rst` at several points inside a stream of valid samples, including one cycle after a sample enters. Each case passes only if the outputs read zero with `out_vld` low for both following edges. Clamping and rounding also meet in one cycle at the range corners, and the exhaustive sweep of every alpha/beta pair at DW = 6 covers them.

// File: rtl/ab_to_phase.sv
module ab_to_phase #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [DW-1:0] alpha,
  input  logic [DW-1:0] beta,
  output logic          out_vld,
  output logic [DW-1:0] ph_a,
  output logic [DW-1:0] ph_b
);
  localparam int FB = 16;
  localparam int XW = DW + FB + 2;
  localparam logic signed [XW-1:0] K_RT3H = XW'(56756);
  localparam logic signed [XW-1:0] HALF   = XW'(1) <<< (FB - 1);
  localparam logic signed [XW-1:0] HI     = (XW'(1) <<< (DW - 1)) - XW'(1);
  localparam logic signed [XW-1:0] LO     = -(XW'(1) <<< (DW - 1));

  logic signed [XW-1:0] be_x, al_x, diff, s1_diff, rnd;
  logic        [DW-1:0] s1_a;
  logic                 s1_v;
  logic        [DW-1:0] clamp;

  assign be_x = XW'($signed(beta));
  assign al_x = XW'($signed(alpha));
  assign diff = be_x * K_RT3H - al_x * HALF;
  assign rnd  = (s1_diff + HALF) >>> FB;

  always_comb begin
    if (rnd > HI)      clamp = HI[DW-1:0];
    else if (rnd < LO) clamp = LO[DW-1:0];
    else               clamp = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_diff <= '0;
      s1_a    <= '0;
      s1_v    <= 1'b0;
      ph_a    <= '0;
      ph_b    <= '0;
      out_vld <= 1'b0;
    end else begin
      s1_diff <= diff;
      s1_a    <= alpha;
      s1_v    <= in_vld;
      ph_a    <= s1_a;
      ph_b    <= clamp;
      out_vld <= s1_v;
    end
  end
endmodule

module ab_to_phase_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic [DW-1:0] alpha,
  input logic [DW-1:0] beta,
  input logic          out_vld,
  input logic [DW-1:0] ph_a,
  input logic [DW-1:0] ph_b
);
  logic [1:0]    runs;
  logic [DW-1:0] a1, a2, b1, b2;
  logic          v1, v2;
  logic signed [DW:0] half_neg;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) runs <= 2'd0;
    else if (runs != 2'd2) runs <= runs + 2'd1;
    a1 <= alpha; a2 <= a1;
    b1 <= beta;  b2 <= b1;
    v1 <= in_vld; v2 <= v1;
  end

  assign half_neg = (-$signed({a2[DW-1], a2}) + (DW+1)'(1)) >>> 1;

  // R1
  phase_a_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (runs == 2'd2) |-> (ph_a == a2));
  // R4
  vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (runs == 2'd2) |-> (out_vld == v2));
  // R2
  round_half_chk: assert property (@(posedge clk) disable iff (rst)
    (runs == 2'd2 && b2 == '0) |-> (ph_b == half_neg[DW-1:0]));
  // R3
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (runs == 2'd2 && b2 == SMIN && a2 == SMAX) |-> (ph_b == SMIN));
  // R3
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (runs == 2'd2 && b2 == SMAX && a2 == SMIN) |-> (ph_b == SMAX));
  // R5
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_vld && ph_a == '0 && ph_b == '0));
endmodule

bind ab_to_phase ab_to_phase_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .alpha(alpha), .beta(beta),
  .out_vld(out_vld), .ph_a(ph_a), .ph_b(ph_b)
);

// File: tb/sim_ab_to_phase.sv
module sim_ab_to_phase;
  localparam int DW = 6;
  localparam int MX = (1 << (DW - 1)) - 1;
  localparam int MN = -(1 << (DW - 1));

  logic clk = 1'b0, rst = 1'b1, in_vld = 1'b0;
  logic [DW-1:0] alpha = '0, beta = '0;
  logic out_vld;
  logic [DW-1:0] ph_a, ph_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  int  m1_a = 0, m1_b = 0, m2_a = 0, m2_b = 0;
  bit  m1_v = 0, m2_v = 0;
  int  rst_age = 0;

  always #4 clk = ~clk;

  ab_to_phase #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .alpha(alpha), .beta(beta),
    .out_vld(out_vld), .ph_a(ph_a), .ph_b(ph_b)
  );

  function automatic int exp_b(int a, int b);
    longint d;
    d = longint'(b) * 56756 - longint'(a) * 32768 + 32768;
    d = d >>> 16;
    if (d > MX) return MX;
    if (d < MN) return MN;
    return int'(d);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit r, bit v, int a, int b);
    int eb;
    @(negedge clk);
    eb = m2_b;
    chk($signed(ph_a) == m2_a, (rst_age < 3) ? "R5 ph_a" : "R1/R6 ph_a", $signed(ph_a), m2_a);
    chk($signed(ph_b) == eb,
        (rst_age < 3) ? "R5 ph_b" : ((eb == MX || eb == MN) ? "R3 ph_b" : "R2 ph_b"),
        $signed(ph_b), eb);
    chk(out_vld == m2_v, (rst_age < 3) ? "R5 out_vld" : "R4 out_vld", out_vld, m2_v);
    rst = r; in_vld = v; alpha = DW'(a); beta = DW'(b);
    if (r) begin
      m2_a = 0; m2_b = 0; m2_v = 0; m1_a = 0; m1_b = 0; m1_v = 0; rst_age = 0;
    end else begin
      m2_a = m1_a; m2_b = exp_b(m1_a, m1_b); m2_v = m1_v;
      m1_a = a; m1_b = b; m1_v = v;
      if (rst_age < 3) rst_age++;
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R5: reset state
    step(1, 0, 0, 0);
    step(1, 1, 5, 5);
    step(0, 0, 0, 0);
    // R1 R2 R3 R4: exhaustive sweep
    for (int a = MN; a <= MX; a++)
      for (int b = MN; b <= MX; b++)
        step(0, ((a + b) & 3) != 0, a, b);
    // R3: explicit corners
    step(0, 1, MX, MN);
    step(0, 1, MN, MX);
    step(0, 1, 1, 0);
    step(0, 1, -1, 0);
    // R5: reset collides with in-flight samples
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 7 + k, -9 + k);
      if (k > 0) step(0, 1, -3 * k, 4 * k);
      step(1, 1, 11, 13);
      step(0, 1, MX, MX);
      step(0, 1, MN, MN);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule